// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns external interrupt pins into request flags for an interrupt controller. Each source has a trigger-mode input. When it is 1, the source fires on a falling edge of the pin. When it is 0, the source fires while the pin is held low. Before any detection, each pin passes through a two-flop synchroniser. The flag is registered one more time after that. A pin change therefore reaches the flag on the third rising clock edge after the pin moves.

In edge mode the flag is a sticky latch. A detected falling edge sets it. A per-source acknowledge strobe from the controller clears it when the handler is vectored. A per-source software write port can also force it to a chosen value. In level mode the flag just shows the inverted synchronised pin, so acknowledge and software writes have no lasting effect. The sources are built from one repeated cell, and no source shares state with another.

An asynchronous active-low reset clears every flag. The reset is released synchronously inside the block.

Top module: `irq_req_latch`

## Requirements
- R1: During reset and after reset is released, every request flag is 0. The synchroniser stages reset to the pin's idle-high value, so releasing reset never creates an edge.
- R2: In level mode (`trig_mode_i` bit = 0), the request flag equals the inverse of the pin value sampled three rising edges earlier.
- R3: In level mode, an acknowledge never clears the flag. While the synchronised pin is low, the flag stays 1.
- R4: In edge mode (`trig_mode_i` bit = 1), a high-to-low change of the pin sets the flag on the third rising edge after the change. A low-to-high change does not set it, and a pin that stays low does not set it again.
- R5: In edge mode, a set flag holds until it is acknowledged or written. An acknowledge clears it on the next rising edge, whatever level the pin has.
- R6: In edge mode, when a detected falling edge and an acknowledge fall on the same cycle, the flag ends up set.
- R7: In edge mode, a software write (`sw_wr_i` bit = 1) loads `sw_data_i` into the flag on the next edge and takes priority over acknowledge. A detected falling edge in the same cycle still forces the flag to 1.
- R8: In level mode, software writes have no effect. The flag keeps following the inverted synchronised pin.
- R9: Each source reacts only to its own pin, mode, acknowledge and write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | NUM_SRC | Raw external interrupt pins (idle high) |
| trig_mode_i | input | NUM_SRC | Per-source mode: 1 = falling edge, 0 = low level |
| vec_ack_i | input | NUM_SRC | Per-source vector-acknowledge strobe |
| sw_wr_i | input | NUM_SRC | Per-source software write enable for the flag |
| sw_data_i | input | NUM_SRC | Value written to the flag |
| irq_req_o | output | NUM_SRC | Per-source request flag |

## Verification
The hardest case to reach from the ports is an acknowledge, or a software write, that lands in exactly the cycle the synchroniser reports a falling edge. That cycle is two edges after the pin is driven low and is never visible at the ports. The stimulus therefore drives the pin low and schedules the acknowledge or write two steps later. It then repeats the sequence with the strobe one step off, to show the ordinary clearing path. A scoreboard model keeps a history of the sampled pin values and works out the expected flag for each edge from those values.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_LOW_LEVEL = 1'b0,
    TRIG_FALL_EDGE = 1'b1
  } trig_mode_e;

  localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync_o = stage_q[1];
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s_o,
  output logic fall_o
);
  import irq_latch_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;
  logic              last_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = pin_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_comb begin
    last_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{PIN_IDLE}};
      last_q  <= PIN_IDLE;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign pin_s_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic pin_s_i,
  input  logic fall_i,
  input  logic ack_i,
  input  logic wr_en_i,
  input  logic wr_data_i,
  output logic req_o
);
  import irq_latch_pkg::*;

  trig_mode_e mode;
  logic       req_q;
  logic       req_d;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    req_d = req_q;
    if (mode == TRIG_FALL_EDGE) begin
      if (fall_i)       req_d = 1'b1;
      else if (wr_en_i) req_d = wr_data_i;
      else if (ack_i)   req_d = 1'b0;
    end else begin
      req_d = ~pin_s_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  assert_ack_kept_in_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i == 1'b0 && ack_i && !pin_s_i) |-> req_q);

  assert_ack_clears_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i && ack_i && !fall_i && !wr_en_i) |-> !req_q);

  assert_fall_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i && fall_i) |-> req_q);

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i && !fall_i && !wr_en_i && !req_q) |-> !req_q);

  assert_write_ignored_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i == 1'b0 && wr_en_i && pin_s_i) |-> !req_q);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_pin_i,
  input  logic [NUM_SRC-1:0] trig_mode_i,
  input  logic [NUM_SRC-1:0] vec_ack_i,
  input  logic [NUM_SRC-1:0] sw_wr_i,
  input  logic [NUM_SRC-1:0] sw_data_i,
  output logic [NUM_SRC-1:0] irq_req_o
);
  logic rst_n_s;

  irq_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic pin_s;
      logic fall;

      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .pin_i   (irq_pin_i[g]),
        .pin_s_o (pin_s),
        .fall_o  (fall)
      );

      irq_req_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .mode_i    (trig_mode_i[g]),
        .pin_s_i   (pin_s),
        .fall_i    (fall),
        .ack_i     (vec_ack_i[g]),
        .wr_en_i   (sw_wr_i[g]),
        .wr_data_i (sw_data_i[g]),
        .req_o     (irq_req_o[g])
      );
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n_s |=> (irq_req_o == '0) || rst_n_s);
endmodule

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '1, mode = '0, ack = '0, wr = '0, wd = '0;
  logic [N-1:0] req;

  irq_req_latch #(.NUM_SRC(N)) u_irq_req_latch (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .trig_mode_i(mode),
    .vec_ack_i(ack), .sw_wr_i(wr), .sw_data_i(wd), .irq_req_o(req)
  );

  always #10 clk = ~clk;

  typedef struct {
    int           cyc;
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t        sb_q[$];
  int           cyc = 0;
  int           n_cmp = 0;
  int           n_bad = 0;
  logic [N-1:0] h1 = '1, h2 = '1, h3 = '1;
  logic [N-1:0] ef = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (req !== it.exp) begin
        n_bad++;
        $display("FAIL %s: irq_req_o=%b expected=%b (cycle %0d)", it.tag, req, it.exp, cyc);
      end
    end
  end

  // driver: applies inputs for the next edge and pushes the expected flags
  task automatic drv(input logic [N-1:0] p, input logic [N-1:0] m, input logic [N-1:0] a,
                     input logic [N-1:0] w, input logic [N-1:0] d, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    pin = p; mode = m; ack = a; wr = w; wd = d;
    for (int s = 0; s < N; s++) begin
      logic f;
      f = h3[s] & ~h2[s];
      if (m[s]) begin
        if (f)         ef[s] = 1'b1;
        else if (w[s]) ef[s] = d[s];
        else if (a[s]) ef[s] = 1'b0;
      end else begin
        ef[s] = ~h2[s];
      end
    end
    h3 = h2; h2 = h1; h1 = p;
    it.cyc = cyc + 1; it.exp = ef; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    n_cmp++;
    if (req !== '0) begin
      n_bad++;
      $display("FAIL R1: in reset irq_req_o=%b expected=00", req);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 3; i++) drv(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, "R1 idle after reset");

    // level mode: follows the inverted pin, acknowledge ignored
    for (int i = 0; i < 5; i++) drv(2'b10, 2'b00, 2'b01, 2'b00, 2'b00, "R2 R3 R9 level low src0 with ack");
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b00, 2'b11, 2'b00, 2'b00, "R2 level release");
    for (int i = 0; i < 3; i++) drv(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, "R2 R9 level low src1");
    // level mode: software writes ignored
    for (int i = 0; i < 4; i++) drv(2'b01, 2'b00, 2'b00, 2'b11, 2'b01, "R8 write in level");
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b00, 2'b00, 2'b11, 2'b11, "R8 write high pin level");

    // edge mode: falling edge sets, held until acknowledge
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R4 edge idle");
    for (int i = 0; i < 5; i++) drv(2'b10, 2'b11, 2'b00, 2'b00, 2'b00, "R4 R9 fall src0");
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R4 R5 rise holds");
    drv(2'b11, 2'b11, 2'b01, 2'b00, 2'b00, "R5 ack clears");
    for (int i = 0; i < 3; i++) drv(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R4 rise no set");

    // coincident fall and acknowledge
    drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R6 pins low");
    drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R6 wait");
    drv(2'b00, 2'b11, 2'b11, 2'b00, 2'b00, "R6 fall with ack");
    for (int i = 0; i < 3; i++) drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R4 R6 still low no reset");
    drv(2'b00, 2'b11, 2'b10, 2'b00, 2'b00, "R5 ack while low");
    for (int i = 0; i < 3; i++) drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R4 low no retrigger");

    // software write in edge mode
    drv(2'b11, 2'b11, 2'b00, 2'b11, 2'b01, "R7 write");
    drv(2'b11, 2'b11, 2'b11, 2'b11, 2'b10, "R7 write over ack");
    for (int i = 0; i < 3; i++) drv(2'b11, 2'b11, 2'b00, 2'b00, 2'b00, "R7 hold");
    drv(2'b11, 2'b11, 2'b11, 2'b00, 2'b00, "R5 clear");
    drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R7 low");
    drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R7 wait");
    drv(2'b00, 2'b11, 2'b00, 2'b11, 2'b00, "R7 fall beats write 0");
    for (int i = 0; i < 3; i++) drv(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R7 kept");

    // mixed modes per source
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b01, 2'b11, 2'b00, 2'b00, "R9 mixed clear");
    for (int i = 0; i < 5; i++) drv(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, "R9 mixed low");
    for (int i = 0; i < 4; i++) drv(2'b11, 2'b01, 2'b00, 2'b00, 2'b00, "R9 mixed release");

    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule